// File: doc/BRIEF.md
# Converter Data-Ready Strobe and Sample Queue

This block produces the active-low data-ready signal of a two-channel sampling converter and holds the samples the host has not yet collected. Each conversion-complete strobe delivers one fresh 24-bit sample for each channel. In the normal case the block answers that strobe with a fixed-width low pulse. A host that services the pulse starts a read, receives a status word and the oldest pair of samples, and then ends the read.

A host can fall behind. If a conversion finishes while a read is still in progress, its pulse is withheld from the pin, but the sample is still kept. Samples wait in a two-entry queue. Samples already waiting produce no new pulse. The host drains them with back-to-back reads, and each read removes one entry. If a sample arrives while the queue is full, the oldest entry is discarded and a sticky overflow bit is raised. The next status read reports that bit and then clears it.

Top module: `adc_drdy_buf`

## Requirements
- R1: A conv_done strobe accepted when no read is active and rd_start is low drives drdy_n low in the cycle after the strobe.
- R2: An accepted strobe holds drdy_n low for exactly PULSE_CYC (default 4) consecutive cycles, after which drdy_n returns high.
- R3: When conversions arrive at a steady period and no read overlaps them, successive falling edges of drdy_n are exactly one conversion period apart.
- R4: A read is active from the cycle rd_start is high through the cycle rd_end is high. A conv_done strobe during an active read produces no low pulse on drdy_n. Its sample is still queued.
- R5: Unread samples are held in a DEPTH-entry queue (default 2), and reads return them oldest first.
- R6: Status bits 0 and 1 are the channel 0 and channel 1 ready flags. Each is 1 while the queue holds at least one entry and 0 once the last entry has been read. Status bits 6:4 hold the number of queued entries. Bits 3 and 7 read as 0.
- R7: A sample arriving while the queue is full and no read pops in the same cycle discards the oldest entry and sets status bit 2. The next rd_start reports the bit and clears it.
- R8: Each rd_start pops one entry. It updates rd_status, rd_ch0 and rd_ch1 in the next cycle with the status and queue state from before the pop, and the outputs hold until the next rd_start. A read of an empty queue returns zero samples. When rd_start and conv_done coincide, the pop is applied before the push.
- R9: A synchronous reset empties the queue, clears the overflow bit and the read outputs, and holds drdy_n high.
- R10: Samples left waiting in the queue never raise a further pulse on drdy_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_done | input | 1 | One-cycle strobe: a new conversion pair is present |
| conv_ch0 | input | 24 | Channel 0 sample, valid with conv_done |
| conv_ch1 | input | 24 | Channel 1 sample, valid with conv_done |
| rd_start | input | 1 | One-cycle strobe: host begins a read |
| rd_end | input | 1 | One-cycle strobe: host finishes the read |
| drdy_n | output | 1 | Active-low data-ready pulse |
| rd_status | output | 8 | Status word captured at read start |
| rd_ch0 | output | 24 | Channel 0 sample returned by the read |
| rd_ch1 | output | 24 | Channel 1 sample returned by the read |

## Verification
Two functions can fall in the same cycle: a conversion strobe and a read. The collision appears in two forms. In the first, conv_done arrives in the very cycle rd_start is asserted, so a pop and a push meet in the queue. In the second, the strobe lands in the middle of a read that is still open. For both forms the bench checks that drdy_n stays high through the following cycles. It also checks that the current read still returns the older entry and that the next read returns the new sample with the right count and flags. A third test fills the queue past its depth and then checks whether the overflow bit shows on exactly one read.

// File: rtl/adc_drdy_pkg.sv
package adc_drdy_pkg;

    localparam int SAMPLE_W   = 24;
    localparam int NUM_CH     = 2;
    localparam int STATUS_W   = 8;
    localparam int ST_OVF_BIT = 2;
    localparam int ST_CNT_LSB = 4;
    localparam int ST_CNT_W   = 3;

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef struct packed {
        sample_t ch1;
        sample_t ch0;
    } frame_t;

    // Assemble the status word from its fields; unused bits read as zero.
    function automatic logic [STATUS_W-1:0] pack_status(
        input logic [NUM_CH-1:0]   rdy,
        input logic                ovf,
        input logic [ST_CNT_W-1:0] cnt
    );
        logic [STATUS_W-1:0] s;
        s = '0;
        s[NUM_CH-1:0] = rdy;
        s[ST_OVF_BIT] = ovf;
        s[ST_CNT_LSB +: ST_CNT_W] = cnt;
        return s;
    endfunction

endpackage

// File: rtl/drdy_pulse.sv
module drdy_pulse #(
    parameter int PULSE_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic drdy_n
);
    localparam int CW = $clog2(PULSE_CYC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (trig) begin
            cnt_q <= CW'(PULSE_CYC);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign drdy_n = (cnt_q == '0);

endmodule

// File: rtl/sample_queue.sv
module sample_queue
    import adc_drdy_pkg::*;
#(
    parameter int DEPTH = 2,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  frame_t           din,
    output frame_t           head,
    output logic [CNT_W-1:0] count,
    output logic             drop_evt
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    frame_t           mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] cnt_q;
    logic             do_pop, full, adv_rd;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign do_pop   = pop && (cnt_q != '0);
    assign full     = (cnt_q == CNT_W'(DEPTH));
    assign drop_evt = push && full && !do_pop;
    assign adv_rd   = do_pop || drop_evt;

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= step(wr_ptr);
            end
            if (adv_rd) begin
                rd_ptr <= step(rd_ptr);
            end
            case ({push, adv_rd})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign head  = mem[rd_ptr];
    assign count = cnt_q;

endmodule

// File: rtl/read_port.sv
module read_port
    import adc_drdy_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rd_start,
    input  logic                rd_end,
    input  frame_t              head,
    input  logic [CNT_W-1:0]    count,
    input  logic                drop_evt,
    output logic                reading,
    output logic [STATUS_W-1:0] status,
    output frame_t              data
);
    logic                reading_q, ovf_q, have;
    logic [NUM_CH-1:0]   rdy;
    logic [STATUS_W-1:0] status_q;
    frame_t              data_q;

    assign have = (count != '0);

    // One ready flag per channel; both follow the shared queue occupancy.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_rdy
        assign rdy[c] = have;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reading_q <= 1'b0;
            ovf_q     <= 1'b0;
            status_q  <= '0;
            data_q    <= '0;
        end else begin
            if (rd_start) begin
                reading_q <= 1'b1;
            end else if (rd_end) begin
                reading_q <= 1'b0;
            end
            ovf_q <= (ovf_q && !rd_start) || drop_evt;
            if (rd_start) begin
                status_q <= pack_status(rdy, ovf_q, ST_CNT_W'(count));
                data_q   <= have ? head : '0;
            end
        end
    end

    assign reading = reading_q;
    assign status  = status_q;
    assign data    = data_q;

endmodule

// File: rtl/adc_drdy_buf.sv
module adc_drdy_buf
    import adc_drdy_pkg::*;
#(
    parameter int DEPTH     = 2,
    parameter int PULSE_CYC = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                conv_done,
    input  logic [SAMPLE_W-1:0] conv_ch0,
    input  logic [SAMPLE_W-1:0] conv_ch1,
    input  logic                rd_start,
    input  logic                rd_end,
    output logic                drdy_n,
    output logic [STATUS_W-1:0] rd_status,
    output logic [SAMPLE_W-1:0] rd_ch0,
    output logic [SAMPLE_W-1:0] rd_ch1
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    frame_t           din, head, rd_data;
    logic [CNT_W-1:0] count;
    logic             drop_evt, reading, trig;

    assign din.ch0 = conv_ch0;
    assign din.ch1 = conv_ch1;

    // A strobe landing in an open read (or its first cycle) is gated off the pin.
    assign trig = conv_done && !(reading || rd_start);

    drdy_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .trig   (trig),
        .drdy_n (drdy_n)
    );

    sample_queue #(.DEPTH(DEPTH)) u_queue (
        .clk      (clk),
        .rst      (rst),
        .push     (conv_done),
        .pop      (rd_start),
        .din      (din),
        .head     (head),
        .count    (count),
        .drop_evt (drop_evt)
    );

    read_port #(.CNT_W(CNT_W)) u_read (
        .clk      (clk),
        .rst      (rst),
        .rd_start (rd_start),
        .rd_end   (rd_end),
        .head     (head),
        .count    (count),
        .drop_evt (drop_evt),
        .reading  (reading),
        .status   (rd_status),
        .data     (rd_data)
    );

    assign rd_ch0 = rd_data.ch0;
    assign rd_ch1 = rd_data.ch1;

endmodule

// File: rtl/adc_drdy_chk.sv
module adc_drdy_chk
    import adc_drdy_pkg::*;
#(
    parameter int DEPTH     = 2,
    parameter int PULSE_CYC = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                conv_done,
    input logic                rd_start,
    input logic                rd_end,
    input logic                drdy_n,
    input logic [ST_CNT_W-1:0] rd_cnt
);
    localparam int LW = $clog2(PULSE_CYC + 2);

    logic          busy_m;
    logic          acc;
    logic [LW-1:0] low_q;

    assign acc = conv_done && !busy_m && !rd_start;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_m <= 1'b0;
        end else if (rd_start) begin
            busy_m <= 1'b1;
        end else if (rd_end) begin
            busy_m <= 1'b0;
        end
    end

    // Counts the low cycles of the current pulse, saturating one past the width.
    always_ff @(posedge clk) begin
        if (rst) begin
            low_q <= '0;
        end else if (acc) begin
            low_q <= LW'(1);
        end else if (!drdy_n && low_q <= LW'(PULSE_CYC)) begin
            low_q <= low_q + 1'b1;
        end else if (drdy_n) begin
            low_q <= '0;
        end
    end

    p_fall_r1: assert property (@(posedge clk) disable iff (rst)
        acc |=> !drdy_n);

    p_low_len_r2: assert property (@(posedge clk) disable iff (rst)
        (low_q != '0 && low_q <= LW'(PULSE_CYC)) |-> !drdy_n);

    p_release_r2: assert property (@(posedge clk) disable iff (rst)
        (low_q > LW'(PULSE_CYC)) |-> drdy_n);

    p_gate_r4: assert property (@(posedge clk) disable iff (rst)
        (conv_done && (busy_m || rd_start) && drdy_n) |=> drdy_n);

    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
        rd_start |=> (rd_cnt <= ST_CNT_W'(DEPTH)));

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !rd_start |=> $stable(rd_cnt));

    p_reset_r9: assert property (@(posedge clk)
        rst |=> (drdy_n && rd_cnt == '0));

endmodule

bind adc_drdy_buf adc_drdy_chk #(
    .DEPTH     (DEPTH),
    .PULSE_CYC (PULSE_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .conv_done (conv_done),
    .rd_start  (rd_start),
    .rd_end    (rd_end),
    .drdy_n    (drdy_n),
    .rd_cnt    (rd_status[adc_drdy_pkg::ST_CNT_LSB +: adc_drdy_pkg::ST_CNT_W])
);

// File: tb/sim_adc_drdy_buf.sv
module sim_adc_drdy_buf;

    localparam int DEPTH = 2;
    localparam int PULSE = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        conv_done = 1'b0;
    logic [23:0] conv_ch0 = '0, conv_ch1 = '0;
    logic        rd_start = 1'b0, rd_end = 1'b0;
    logic        drdy_n;
    logic [7:0]  rd_status;
    logic [23:0] rd_ch0, rd_ch1;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    logic [47:0] mq [$];
    logic        movf = 1'b0;
    logic [55:0] sbq [$];
    logic        rd_seen = 1'b0;
    logic        prev_drdy = 1'b1;
    int          last_fall = 0;
    int          nfall = 0;
    int          gaps [8];

    adc_drdy_buf #(.DEPTH(DEPTH), .PULSE_CYC(PULSE)) u0 (
        .clk(clk), .rst(rst), .conv_done(conv_done), .conv_ch0(conv_ch0),
        .conv_ch1(conv_ch1), .rd_start(rd_start), .rd_end(rd_end),
        .drdy_n(drdy_n), .rd_status(rd_status), .rd_ch0(rd_ch0), .rd_ch1(rd_ch1)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // Model of the queue, written from the requirements.
    task automatic model_push(input logic [23:0] a, input logic [23:0] b);
        if (mq.size() == DEPTH) begin
            void'(mq.pop_front());
            movf = 1'b1;
        end
        mq.push_back({a, b});
    endtask

    task automatic model_read();
        logic [7:0]  st;
        logic [47:0] d;
        int          n;
        n  = mq.size();
        st = {1'b0, 3'(n), 1'b0, movf, (n > 0) ? 2'b11 : 2'b00};
        d  = (n > 0) ? mq.pop_front() : 48'h0;
        movf = 1'b0;
        sbq.push_back({st, d});
    endtask

    // Scoreboard monitor: compares one expected item per read.
    always @(posedge clk) rd_seen <= rd_start;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (sbq.size() == 0) begin
                check("R8 unexpected read", 64'h1, 64'h0);
            end else begin
                logic [55:0] e;
                e = sbq.pop_front();
                check("R8/R5/R6/R7 read result", {rd_status, rd_ch0, rd_ch1}, e);
            end
        end
    end

    always @(negedge clk) begin
        if (prev_drdy && !drdy_n) begin
            if (nfall < 8) gaps[nfall] = cyc - last_fall;
            last_fall = cyc;
            nfall++;
        end
        prev_drdy = drdy_n;
    end

    task automatic conv(input logic [23:0] a, input logic [23:0] b);
        @(negedge clk);
        conv_done = 1'b1; conv_ch0 = a; conv_ch1 = b;
        model_push(a, b);
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    task automatic do_read();
        @(negedge clk);
        rd_start = 1'b1;
        model_read();
        @(negedge clk);
        rd_start = 1'b0; rd_end = 1'b1;
        @(negedge clk);
        rd_end = 1'b0;
    endtask

    task automatic expect_high(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            check(req, 64'(drdy_n), 64'h1);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9: reset state
        check("R9 drdy_n after reset", 64'(drdy_n), 64'h1);
        check("R9 status after reset", 64'(rd_status), 64'h0);
        check("R9 data after reset", 64'({rd_ch0, rd_ch1}), 64'h0);

        // R1/R2: single pulse width
        conv(24'h123456, 24'hABCDEF);
        for (int i = 0; i < PULSE; i++) begin
            check("R1/R2 drdy_n low", 64'(drdy_n), 64'h0);
            @(negedge clk);
        end
        check("R2 drdy_n released", 64'(drdy_n), 64'h1);
        do_read();   // R5/R6/R8 single entry
        expect_high("R10 no pulse after read", 4);

        // R3: steady 20-cycle period with a read between conversions
        nfall = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            conv_done = 1'b1; conv_ch0 = 24'(k + 16); conv_ch1 = 24'(k + 32);
            model_push(24'(k + 16), 24'(k + 32));
            @(negedge clk);
            conv_done = 1'b0;
            repeat (5) @(negedge clk);
            do_read();
            repeat (10) @(negedge clk);
        end
        check("R3 fall count", 64'(nfall), 64'd4);
        for (int k = 1; k < 4; k++) check("R3 fall spacing", 64'(gaps[k]), 64'd20);

        // R4/R10: conversion during an open read is gated from the pin
        conv(24'h000111, 24'h000222);
        repeat (6) @(negedge clk);
        @(negedge clk);
        rd_start = 1'b1;
        model_read();
        @(negedge clk);
        rd_start = 1'b0;
        conv_done = 1'b1; conv_ch0 = 24'h0A0A0A; conv_ch1 = 24'h0B0B0B;
        model_push(24'h0A0A0A, 24'h0B0B0B);
        @(negedge clk);
        conv_done = 1'b0;
        expect_high("R4 gated pulse", 5);
        rd_end = 1'b1;
        @(negedge clk);
        rd_end = 1'b0;
        expect_high("R10 queued sample no pulse", 4);
        do_read();   // R4: gated sample still delivered

        // R4/R8: conv_done in the same cycle as rd_start
        conv(24'h00C0DE, 24'h00F00D);
        repeat (6) @(negedge clk);
        @(negedge clk);
        rd_start = 1'b1;
        model_read();
        conv_done = 1'b1; conv_ch0 = 24'h777777; conv_ch1 = 24'h888888;
        model_push(24'h777777, 24'h888888);
        @(negedge clk);
        rd_start = 1'b0; conv_done = 1'b0; rd_end = 1'b1;
        check("R4 coincident strobe gated", 64'(drdy_n), 64'h1);
        @(negedge clk);
        rd_end = 1'b0;
        expect_high("R4 coincident strobe gated", 3);
        do_read();

        // R7: three samples into a two-deep queue, then drain
        conv(24'h100001, 24'h200001);
        repeat (6) @(negedge clk);
        conv(24'h100002, 24'h200002);
        repeat (6) @(negedge clk);
        conv(24'h100003, 24'h200003);
        repeat (6) @(negedge clk);
        do_read();   // R7: overflow reported
        do_read();   // R7: overflow cleared
        do_read();   // R6/R8: empty read
        check("R6 flags after drain", 64'(rd_status[1:0]), 64'h0);

        // R9: reset mid-activity
        conv(24'h5A5A5A, 24'hA5A5A5);
        @(negedge clk);
        rst = 1'b1;
        mq.delete(); movf = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R9 drdy_n high after reset", 64'(drdy_n), 64'h1);
        do_read();   // R9: queue empty after reset

        repeat (4) @(negedge clk);
        check("R8 scoreboard drained", 64'(sbq.size()), 64'h0);
        finish_up();
    end

endmodule